// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM with 16-bit words and separate low/high byte enables. The host presents a single read or write at a time: a request, a direction flag, a 17-bit word address, write data and a two-bit byte mask. The sequencer turns each request into a pin sequence on chip enable, write enable, output enable, the byte enables and a split data bus (outgoing data, incoming data and a drive-enable for the pad). Every pin sequence meets the memory's minimum intervals. Each interval is a nanosecond figure turned into whole clock cycles by rounding up, with a floor of one cycle. The rounding is computed at elaboration from a clock-period parameter.

Two rules go beyond plain cycle stretching. After reset the block stays busy and keeps the memory deselected for the power-up wait of 200 µs. Once the memory has stopped driving, it also leaves bus-turnaround gaps. During a write, data is not placed on the bus until the memory's output-release time after write enable falls. After a read, chip and output enable stay high for the memory's output-float time before any new access starts.

Top module: `sramCtl`

## Requirements
- R1: From reset release, hostReady stays low and memCeN, memWeN and memOeN stay high with memDqOe low for ceil(200000 ns / period) cycles. hostReady then rises, and a request held during that wait starts no access.
- R2: A read holds memCeN and memOeN low with memWeN high for exactly max(ceil(45/T), ceil(22/T)) cycles. rdValid is a one-cycle pulse seen in the (that count + 1)th cycle after the accepting edge, carrying the addressed word.
- R3: A write holds memWeN low for exactly max(ceil(35/T), ceil(18/T)+ceil(25/T)) cycles, with memCeN low and memOeN high in every one of them.
- R4: memDqOe rises ceil(18/T) cycles after memWeN falls and stays high until the edge on which memWeN rises, where it falls. It is never high while memWeN is high.
- R5: hostMask bit 0 selects data bits 7:0 and drives memBeN[0] low; bit 1 selects bits 15:8 and drives memBeN[1] low; both enables are high whenever memCeN is high. A write changes only the selected bytes. A read returns zero in unselected bytes.
- R6: After a read, memCeN stays high at least ceil(18/T) cycles before the next access begins.
- R7: Successive falling edges of memCeN are at least ceil(45/T) cycles apart.
- R8: memAddr shows the requested address from the accepting edge on and does not change while memCeN is low.
- R9: A request is taken only on an edge where hostReady is high. Address, data, mask and request changes while busy have no effect on the access in flight or on memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, period CLK_PERIOD_NS |
| rstN | input | 1 | Asynchronous active-low reset |
| hostReq | input | 1 | Access request, taken when hostReady is high |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 17 | Word address |
| hostWrData | input | 16 | Write data |
| hostMask | input | 2 | Byte select, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| hostReady | output | 1 | Idle and able to take a request |
| rdData | output | 16 | Read result, unselected bytes zero |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| memAddr | output | 17 | Memory address pins |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | 2 | Byte enables, active low, bit 0 = low byte |
| memDqOut | output | 16 | Data toward the memory |
| memDqOe | output | 1 | Pad drive enable for memDqOut |
| memDqIn | input | 16 | Data from the memory pins |

## Verification
All memory pins are registered, so each strobe reaches the pins one edge after the sequencer state that asks for it. The bench therefore measures pin intervals by counting falling clock edges between pin transitions and compares each count with the exact figure from R2 to R4. rdValid is due the read-strobe count plus one cycles after the accepting edge, and the bench counts falling edges from acceptance to the pulse before comparing rdData. The address is checked on the first falling edge after acceptance. Power-up latency is counted from reset release to the first falling edge with hostReady high.

// File: rtl/sramCtlPkg.sv
package sramCtlPkg;

  // Per-cycle requests from the sequencer to the pin datapath.
  typedef struct packed {
    logic load;     // latch host address, data and mask
    logic ceAct;    // chip selected
    logic weAct;    // write strobe active
    logic oeAct;    // memory output enabled
    logic drive;    // controller drives the data bus
    logic capture;  // sample the data bus into rdData
  } ctlStrobeT;

  // Whole cycles covering a nanosecond limit, never fewer than one.
  function automatic int nsToCyc(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramCtlFsm.sv
module sramCtlFsm
  import sramCtlPkg::*;
#(
  parameter int PU_CYC  = 20000,
  parameter int RD_CYC  = 5,
  parameter int FLT_CYC = 2,
  parameter int HIZ_CYC = 2,
  parameter int WP_CYC  = 5,
  parameter int REC_CYC = 0
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      hostReq,
  input  logic      hostWrite,
  output logic      hostReady,
  output ctlStrobeT strobe
);

  localparam int LONGEST = maxOf(maxOf(PU_CYC, RD_CYC),
                                 maxOf(maxOf(FLT_CYC, WP_CYC), maxOf(HIZ_CYC, REC_CYC)));
  localparam int CNT_W = $clog2(LONGEST + 1);

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_READ,
    ST_FLOAT,
    ST_WRITE,
    ST_RECOV
  } stateT;

  stateT            state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  function automatic logic atLast(input logic [CNT_W-1:0] c, input int len);
    return c == CNT_W'(len - 1);
  endfunction

  always_comb begin
    stateNext = state;
    cntNext   = cnt + 1'b1;
    strobe    = '0;
    hostReady = 1'b0;
    case (state)
      ST_PWRUP: begin
        if (atLast(cnt, PU_CYC)) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      end
      ST_IDLE: begin
        hostReady = 1'b1;
        cntNext   = '0;
        if (hostReq) begin
          strobe.load = 1'b1;
          stateNext   = hostWrite ? ST_WRITE : ST_READ;
        end
      end
      ST_READ: begin
        strobe.ceAct = 1'b1;
        strobe.oeAct = 1'b1;
        if (atLast(cnt, RD_CYC)) begin
          stateNext = ST_FLOAT;
          cntNext   = '0;
        end
      end
      ST_FLOAT: begin
        // first float cycle: pins still low, data settled, sample now
        strobe.capture = (cnt == '0);
        if (atLast(cnt, FLT_CYC)) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      end
      ST_WRITE: begin
        strobe.ceAct = 1'b1;
        strobe.weAct = 1'b1;
        strobe.drive = (cnt >= CNT_W'(HIZ_CYC));
        if (atLast(cnt, WP_CYC)) begin
          stateNext = (REC_CYC > 0) ? ST_RECOV : ST_IDLE;
          cntNext   = '0;
        end
      end
      ST_RECOV: begin
        if (atLast(cnt, REC_CYC)) begin
          stateNext = ST_IDLE;
          cntNext   = '0;
        end
      end
      default: begin
        stateNext = ST_PWRUP;
        cntNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PWRUP;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

endmodule

// File: rtl/sramCtlPath.sv
module sramCtlPath
  import sramCtlPkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobeT         strobe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W/8-1:0] hostMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int BYTES = DATA_W / 8;

  logic [BYTES-1:0]  maskQ;
  logic [BYTES-1:0]  beNext;
  logic [DATA_W-1:0] rdLane;

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    assign beNext[l]        = ~(strobe.ceAct & maskQ[l]);
    assign rdLane[l*8 +: 8] = maskQ[l] ? memDqIn[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
      maskQ    <= '0;
      memCeN   <= 1'b1;
      memWeN   <= 1'b1;
      memOeN   <= 1'b1;
      memBeN   <= '1;
      memDqOe  <= 1'b0;
      rdData   <= '0;
      rdValid  <= 1'b0;
    end else begin
      if (strobe.load) begin
        memAddr  <= hostAddr;
        memDqOut <= hostWrData;
        maskQ    <= hostMask;
      end
      memCeN  <= ~strobe.ceAct;
      memWeN  <= ~strobe.weAct;
      memOeN  <= ~strobe.oeAct;
      memBeN  <= beNext;
      memDqOe <= strobe.drive;
      rdValid <= strobe.capture;
      if (strobe.capture) rdData <= rdLane;
    end
  end

endmodule

// File: rtl/sramCtl.sv
module sramCtl
  import sramCtlPkg::*;
#(
  parameter int CLK_PERIOD_NS      = 10,
  parameter int ADDR_W             = 17,
  parameter int DATA_W             = 16,
  parameter int T_READ_CYCLE_NS    = 45,
  parameter int T_ADDR_ACCESS_NS   = 45,
  parameter int T_OE_DATA_NS       = 22,
  parameter int T_OUT_FLOAT_NS     = 18,
  parameter int T_WE_PULSE_NS      = 35,
  parameter int T_ADDR_TO_WEND_NS  = 35,
  parameter int T_DATA_SETUP_NS    = 25,
  parameter int T_WE_RELEASE_NS    = 18,
  parameter int T_WRITE_CYCLE_NS   = 45,
  parameter int PWRUP_NS           = 200000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostReq,
  input  logic                hostWrite,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [DATA_W/8-1:0] hostMask,
  output logic                hostReady,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdValid,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCeN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn
);

  localparam int PU_CYC  = nsToCyc(PWRUP_NS, CLK_PERIOD_NS);
  localparam int RD_CYC  = maxOf(maxOf(nsToCyc(T_READ_CYCLE_NS, CLK_PERIOD_NS),
                                       nsToCyc(T_ADDR_ACCESS_NS, CLK_PERIOD_NS)),
                                 nsToCyc(T_OE_DATA_NS, CLK_PERIOD_NS));
  localparam int FLT_CYC = nsToCyc(T_OUT_FLOAT_NS, CLK_PERIOD_NS);
  localparam int HIZ_CYC = nsToCyc(T_WE_RELEASE_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = maxOf(maxOf(nsToCyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                       nsToCyc(T_ADDR_TO_WEND_NS, CLK_PERIOD_NS)),
                                 HIZ_CYC + nsToCyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int REC_CYC = maxOf(0, nsToCyc(T_WRITE_CYCLE_NS, CLK_PERIOD_NS) - WP_CYC);

  ctlStrobeT strobe;

  sramCtlFsm #(
    .PU_CYC (PU_CYC),
    .RD_CYC (RD_CYC),
    .FLT_CYC(FLT_CYC),
    .HIZ_CYC(HIZ_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .hostReq  (hostReq),
    .hostWrite(hostWrite),
    .hostReady(hostReady),
    .strobe   (strobe)
  );

  sramCtlPath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostAddr  (hostAddr),
    .hostWrData(hostWrData),
    .hostMask  (hostMask),
    .memDqIn   (memDqIn),
    .memAddr   (memAddr),
    .memCeN    (memCeN),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memBeN    (memBeN),
    .memDqOut  (memDqOut),
    .memDqOe   (memDqOe),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );

endmodule

// File: rtl/sramCtlChk.sv
module sramCtlChk #(
  parameter int ADDR_W  = 17,
  parameter int BYTES   = 2,
  parameter int PU_CYC  = 20000,
  parameter int RD_CYC  = 5,
  parameter int FLT_CYC = 2,
  parameter int HIZ_CYC = 2,
  parameter int WP_CYC  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memOeN,
  input logic [BYTES-1:0]  memBeN,
  input logic              memDqOe
);

  localparam int PU_W = $clog2(PU_CYC + 1);

  logic [PU_W-1:0] puCnt;
  logic [15:0]     weLowCnt, ceLowCnt, ceHighCnt;
  logic            lastRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      puCnt     <= '0;
      weLowCnt  <= '0;
      ceLowCnt  <= '0;
      ceHighCnt <= '0;
      lastRead  <= 1'b0;
    end else begin
      if (puCnt != PU_W'(PU_CYC)) puCnt <= puCnt + 1'b1;
      weLowCnt  <= memWeN  ? 16'd0 : ((weLowCnt  == 16'hFFFF) ? weLowCnt  : weLowCnt  + 16'd1);
      ceLowCnt  <= memCeN  ? 16'd0 : ((ceLowCnt  == 16'hFFFF) ? ceLowCnt  : ceLowCnt  + 16'd1);
      ceHighCnt <= !memCeN ? 16'd0 : ((ceHighCnt == 16'hFFFF) ? ceHighCnt : ceHighCnt + 16'd1);
      if (!memCeN && !memOeN) lastRead <= 1'b1;
      else if (!memWeN)       lastRead <= 1'b0;
    end
  end

  a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rstN)
    (puCnt < PU_W'(PU_CYC)) |-> (memCeN && memWeN && memOeN && !memDqOe && !hostReady));

  a_r2_read_width: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(memCeN) && lastRead) |-> (ceLowCnt == 16'(RD_CYC)));

  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r3_we_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (weLowCnt == 16'(WP_CYC)));

  a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  a_r4_release_wait: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && memOeN && (weLowCnt >= 16'(HIZ_CYC))));

  a_r5_lanes_idle: assert property (@(posedge clk) disable iff (!rstN)
    memCeN |-> (memBeN == '1));

  a_r6_float_gap: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCeN) && lastRead) |-> (ceHighCnt >= 16'(FLT_CYC)));

  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

endmodule

bind sramCtl sramCtlChk #(
  .ADDR_W (ADDR_W),
  .BYTES  (DATA_W / 8),
  .PU_CYC (PU_CYC),
  .RD_CYC (RD_CYC),
  .FLT_CYC(FLT_CYC),
  .HIZ_CYC(HIZ_CYC),
  .WP_CYC (WP_CYC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostReady(hostReady),
  .rdValid  (rdValid),
  .memAddr  (memAddr),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memOeN   (memOeN),
  .memBeN   (memBeN),
  .memDqOe  (memDqOe)
);

// File: tb/sramCtl_tb.sv
module sramModelTb (
  input  logic        clk,
  input  logic [16:0] addr,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  input  logic [1:0]  beN,
  input  logic [15:0] dqFromCtl,
  input  logic        dqCtlOe,
  output logic [15:0] dqToCtl
);
  logic [15:0] mem [0:255];

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  end

  always_comb begin
    for (int l = 0; l < 2; l++)
      dqToCtl[l*8 +: 8] = (!ceN && !oeN && weN && !beN[l]) ? mem[addr[7:0]][l*8 +: 8] : 8'hEE;
  end

  always @(negedge clk) begin
    if (!ceN && !weN && dqCtlOe)
      for (int l = 0; l < 2; l++)
        if (!beN[l]) mem[addr[7:0]][l*8 +: 8] <= dqFromCtl[l*8 +: 8];
  end
endmodule

module sramCtl_tb;
  localparam int CLK_NS  = 10;
  localparam int EXP_PU  = (200000 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_RC  = (45 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_OE  = (22 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_RD  = (EXP_RC > EXP_OE) ? EXP_RC : EXP_OE;
  localparam int EXP_HIZ = (18 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_DS  = (25 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_PW  = (35 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WP  = (EXP_PW > EXP_HIZ + EXP_DS) ? EXP_PW : EXP_HIZ + EXP_DS;
  localparam int EXP_FLT = (18 + CLK_NS - 1) / CLK_NS;
  localparam int EXP_WC  = (45 + CLK_NS - 1) / CLK_NS;

  typedef struct packed {
    logic        wr;
    logic [16:0] addr;
    logic [15:0] data;
    logic [1:0]  mask;
    logic [15:0] expd;
  } vecT;

  localparam int NVEC = 13;
  localparam vecT VECS [0:NVEC-1] = '{
    '{1'b1, 17'h00005, 16'h1234, 2'b11, 16'h0000},
    '{1'b0, 17'h00005, 16'h0000, 2'b11, 16'h1234},
    '{1'b1, 17'h00005, 16'hABCD, 2'b01, 16'h0000},
    '{1'b0, 17'h00005, 16'h0000, 2'b11, 16'h12CD},
    '{1'b1, 17'h00005, 16'h5678, 2'b10, 16'h0000},
    '{1'b0, 17'h00005, 16'h0000, 2'b11, 16'h56CD},
    '{1'b0, 17'h00005, 16'h0000, 2'b01, 16'h00CD},
    '{1'b0, 17'h00005, 16'h0000, 2'b10, 16'h5600},
    '{1'b1, 17'h1FFFF, 16'hFFFF, 2'b11, 16'h0000},
    '{1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'hFFFF},
    '{1'b1, 17'h000AA, 16'hA5A5, 2'b11, 16'h0000},
    '{1'b0, 17'h000AA, 16'h0000, 2'b11, 16'hA5A5},
    '{1'b0, 17'h00000, 16'h0000, 2'b11, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0;
  logic        hostWrite = 1'b0;
  logic [16:0] hostAddr = '0;
  logic [15:0] hostWrData = '0;
  logic [1:0]  hostMask = '0;
  logic        hostReady, rdValid;
  logic [15:0] rdData;
  logic [16:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDqOe;
  logic [1:0]  memBeN;
  logic [15:0] memDqOut, memDqIn;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 0;

  always #(CLK_NS / 2) clk = ~clk;

  sramCtl u_dut (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostMask(hostMask),
    .hostReady(hostReady), .rdData(rdData), .rdValid(rdValid),
    .memAddr(memAddr), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  sramModelTb u_mem (
    .clk(clk), .addr(memAddr), .ceN(memCeN), .weN(memWeN), .oeN(memOeN),
    .beN(memBeN), .dqFromCtl(memDqOut), .dqCtlOe(memDqOe), .dqToCtl(memDqIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pin-interval monitor, sampled on falling edges
  bit        prevWeN = 1, prevCeN = 1;
  int        weRun = 0, driveStart = 0, driveLast = 0;
  bit        oeBad = 0, driveBad = 0;
  int        ceRun = 0, ceHigh = 0, fallGap = 0;
  bit        rdAcc = 0, lastWasRead = 0, seenAccess = 0, addrBad = 0;
  logic [16:0] ceAddr = '0;

  always @(negedge clk) begin
    if (monOn) begin
      if (!prevWeN && memWeN) begin
        chk(weRun == EXP_WP, "R3 write strobe width", weRun, EXP_WP);
        chk(!oeBad, "R3 OE high and CE low during write", oeBad, 0);
        chk(driveStart == EXP_HIZ + 1, "R4 first driven cycle", driveStart, EXP_HIZ + 1);
        chk(driveLast == weRun && !driveBad && !memDqOe, "R4 drive ends at WE rise", driveLast, weRun);
        weRun = 0; driveStart = 0; driveLast = 0; oeBad = 0; driveBad = 0;
      end
      if (prevCeN && !memCeN) begin
        if (seenAccess) begin
          chk(fallGap >= EXP_WC, "R7 access spacing", fallGap, EXP_WC);
          if (lastWasRead) chk(ceHigh >= EXP_FLT, "R6 float gap after read", ceHigh, EXP_FLT);
        end
        seenAccess = 1; ceHigh = 0; fallGap = 0;
      end
      if (!prevCeN && memCeN) begin
        if (rdAcc) chk(ceRun == EXP_RD, "R2 read strobe width", ceRun, EXP_RD);
        chk(!addrBad, "R8 address steady under CE", addrBad, 0);
        chk(memBeN == 2'b11, "R5 byte enables off with CE high", memBeN, 3);
        lastWasRead = rdAcc; rdAcc = 0; ceRun = 0; addrBad = 0;
      end
      if (!memWeN) begin
        weRun++;
        if (!memOeN || memCeN) oeBad = 1;
      end
      if (memDqOe) begin
        if (memWeN) driveBad = 1;
        if (driveStart == 0) driveStart = weRun;
        driveLast = weRun;
      end
      if (!memCeN) begin
        ceRun++;
        if (!memOeN) rdAcc = 1;
        if (ceRun == 1) ceAddr = memAddr;
        else if (memAddr != ceAddr) addrBad = 1;
      end else begin
        ceHigh++;
      end
      fallGap++;
      prevWeN = memWeN;
      prevCeN = memCeN;
    end
  end

  task automatic access(input bit wr, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input logic [15:0] expd);
    int n;
    n = 0;
    while (!hostReady && n < 100) begin @(negedge clk); n++; end
    hostReq = 1'b1; hostWrite = wr; hostAddr = a; hostWrData = d; hostMask = m;
    @(negedge clk);
    hostReq = 1'b0;
    chk(memAddr == a, "R8 address on pins after accept", memAddr, a);
    if (!wr) begin
      n = 0;
      while (!rdValid && n < 40) begin @(negedge clk); n++; end
      chk(n == EXP_RD + 1, "R2 read result latency", n, EXP_RD + 1);
      chk(rdData == expd, "R2 R5 read data", rdData, expd);
      @(negedge clk);
      chk(!rdValid, "R2 valid is one cycle", rdValid, 0);
    end else begin
      n = 0;
      while (!hostReady && n < 40) begin @(negedge clk); n++; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    bit quietBad;
    repeat (3) @(negedge clk);
    chk(!hostReady && memCeN && memWeN && memOeN && !memDqOe && !rdValid,
        "R1 reset state", {hostReady, memCeN, memWeN, memOeN, memDqOe}, 5'b01110);
    rstN = 1'b1;
    monOn = 1;
    // request held during the wait must not start anything
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00033; hostWrData = 16'hBEEF; hostMask = 2'b11;
    n = 0; quietBad = 0;
    while (!hostReady && n < EXP_PU + 50) begin
      @(negedge clk);
      n++;
      if (n == 100) hostReq = 1'b0;
      if (!memCeN || !memWeN || !memOeN || memDqOe) quietBad = 1;
    end
    chk(n == EXP_PU, "R1 power-up wait length", n, EXP_PU);
    chk(!quietBad, "R1 R9 pins quiet during power-up", quietBad, 0);

    for (int i = 0; i < NVEC; i++)
      access(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].mask, VECS[i].expd);

    // R9: changes while busy are ignored
    while (!hostReady) @(negedge clk);
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 17'h00007; hostWrData = 16'h1111; hostMask = 2'b11;
    @(negedge clk);
    hostAddr = 17'h00008; hostWrData = 16'h2222; hostMask = 2'b01;
    chk(!hostReady, "R9 busy after accept", hostReady, 0);
    @(negedge clk);
    chk(memAddr == 17'h00007, "R9 address kept while busy", memAddr, 17'h00007);
    @(negedge clk);
    hostReq = 1'b0;
    access(1'b0, 17'h00008, 16'h0000, 2'b11, 16'h0000);
    access(1'b0, 17'h00007, 16'h0000, 2'b11, 16'h1111);
    // read immediately followed by write, then read back
    access(1'b1, 17'h00009, 16'h0F0F, 2'b11, 16'h0000);
    access(1'b0, 17'h00009, 16'h0000, 2'b11, 16'h0F0F);

    repeat (10) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule